// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block sits between instruction fetch and the execution lanes of a multithreaded streaming core. It keeps one buffered, already decoded instruction for each resident warp. For every warp it also keeps a register scoreboard: one pending-write bit per architectural register. In each cycle it picks at most one buffered instruction whose operands are free of pending writes, and presents that instruction together with the warp number. The lanes then broadcast the instruction to every thread of the warp.

Fetch places one instruction per cycle into the empty slot of the warp it names. A `slotFree` vector tells fetch which warps can take a new instruction. When an instruction issues, its slot empties and the pending bit of its destination register is set. The bit clears later through either of two return paths: the arithmetic write-back port or the memory-return port.

Moving from one warp to another costs nothing, so back-to-back issues may come from different warps. A warp whose long-latency load is still outstanding can go on issuing any instruction that does not touch the load's destination.

The selection rule has two levels. The instruction that has waited longest wins. When several instructions are equally old, the tie goes to the first warp in round-robin order after the warp that issued most recently. A waiting instruction's age stops rising once it reaches the largest value the age counter can hold.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst_n` is low and after its release, every slot is empty, every scoreboard bit is clear, `issueValid` is 0 and `slotFree` is all ones.
- R2: A fetch with `fetchValid`=1 to a warp number below NUM_WARPS whose slot is empty fills that slot on the clock edge. From the next cycle `slotFree[warp]` is 0 and the instruction can issue. A fetch to a warp number of NUM_WARPS or above is dropped.
- R3: A fetch to a warp whose slot is occupied is dropped, and the buffered instruction is kept unchanged.
- R4: An instruction is held while any source it uses (`useA`/`useB` set) has its scoreboard bit set in its own warp.
- R5: An instruction with `writes`=1 is held while its own destination register has a pending write.
- R6: On issue the slot empties on the same edge, and, if `writes`=1, the destination's scoreboard bit is set.
- R7: A write-back or memory return (warp, register) clears that bit on the edge. Both ports may clear in the same cycle. A held instruction can issue in the cycle after the clearing edge.
- R8: At most one instruction issues per cycle. It is always an eligible one. If any instruction is eligible, one issues. Consecutive cycles may issue from different warps.
- R9: Among eligible instructions, the one with the largest age issues first. Age is 0 at fill and rises by one for each edge that the instruction waits in its slot.
- R10: Age saturates at 2^AGE_W-1. Among eligible instructions of equal age, the first warp after the last issued warp in ascending circular order wins. After reset, the search starts at warp 0.
- R11: Pending bits are kept per warp; a pending register in one warp never holds an instruction of another warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | Fetch offers an instruction this cycle |
| fetchWarp | input | 5 | Warp the fetched instruction belongs to |
| fetchOp | input | 8 | Opcode of the fetched instruction |
| fetchDst | input | 4 | Destination register |
| fetchSrcA | input | 4 | First source register |
| fetchSrcB | input | 4 | Second source register |
| fetchUseA | input | 1 | First source is read |
| fetchUseB | input | 1 | Second source is read |
| fetchWrites | input | 1 | Instruction writes its destination |
| wbValid | input | 1 | Arithmetic write-back clears a pending bit |
| wbWarp | input | 5 | Warp of the write-back |
| wbReg | input | 4 | Register of the write-back |
| memValid | input | 1 | Memory return clears a pending bit |
| memWarp | input | 5 | Warp of the memory return |
| memReg | input | 4 | Register of the memory return |
| slotFree | output | NUM_WARPS | Per-warp empty-slot flags for fetch |
| issueValid | output | 1 | An instruction issues this cycle |
| issueWarp | output | 5 | Warp being issued |
| issueOp | output | 8 | Opcode being issued |
| issueDst | output | 4 | Destination register being issued |
| issueSrcA | output | 4 | First source being issued |
| issueSrcB | output | 4 | Second source being issued |
| issueUseA | output | 1 | First source is read |
| issueUseB | output | 1 | Second source is read |
| issueWrites | output | 1 | Issued instruction writes its destination |

## Verification
Two pairs of events can land in the same cycle. In the first, the write-back and memory-return ports both clear bits on one edge, in different warps or for different registers. In the second, a clear on one warp meets an issue or a fill on another. The stimulus table sets up both cases on purpose. In one case, two warps are parked on pending registers and both are released on one edge. Each release is judged by which warp issues on the following cycle and in what order, since that order also shows whether the age and round-robin rules were applied to the pair.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  localparam int MAX_WARPS = 32;
  localparam int WARP_ID_W = $clog2(MAX_WARPS);
  localparam int NUM_REGS  = 16;
  localparam int REG_W     = $clog2(NUM_REGS);
  localparam int OPC_W     = 8;

  typedef logic [WARP_ID_W-1:0] warp_id_t;
  typedef logic [REG_W-1:0]     reg_id_t;

  typedef struct packed {
    logic [OPC_W-1:0] op;
    reg_id_t          dst;
    reg_id_t          srcA;
    reg_id_t          srcB;
    logic             useA;
    logic             useB;
    logic             writes;
  } winstr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     fetchEn;
    logic     issueEn;
    warp_id_t issueWarp;
  } strobe_t;

endpackage

// File: rtl/wsched_datapath.sv
module wsched_datapath
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int AGE_W     = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  strobe_t                         strb,
  input  warp_id_t                        fetchWarp,
  input  winstr_t                         fetchInstr,
  input  logic                            wbValid,
  input  warp_id_t                        wbWarp,
  input  reg_id_t                         wbReg,
  input  logic                            memValid,
  input  warp_id_t                        memWarp,
  input  reg_id_t                         memReg,
  output logic [NUM_WARPS-1:0]            slotValid,
  output logic [NUM_WARPS-1:0]            readyVec,
  output logic [NUM_WARPS-1:0][AGE_W-1:0] ageVec,
  output winstr_t                         issueInstr
);

  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  winstr_t                          slotData [NUM_WARPS];
  logic [NUM_WARPS-1:0][NUM_REGS-1:0] sbq;

  // per-warp slot with its age counter
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    logic fillHere;
    logic issueHere;
    assign fillHere  = strb.fetchEn && (fetchWarp == WARP_ID_W'(w));
    assign issueHere = strb.issueEn && (strb.issueWarp == WARP_ID_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slotValid[w] <= 1'b0;
        slotData[w]  <= '0;
        ageVec[w]    <= '0;
      end else if (fillHere) begin
        slotValid[w] <= 1'b1;
        slotData[w]  <= fetchInstr;
        ageVec[w]    <= '0;
      end else if (issueHere) begin
        slotValid[w] <= 1'b0;
      end else if (slotValid[w] && ageVec[w] != AGE_MAX) begin
        ageVec[w] <= ageVec[w] + 1'b1;
      end
    end

    logic rawA, rawB, waw;
    assign rawA = slotData[w].useA   && sbq[w][slotData[w].srcA];
    assign rawB = slotData[w].useB   && sbq[w][slotData[w].srcB];
    assign waw  = slotData[w].writes && sbq[w][slotData[w].dst];
    assign readyVec[w] = slotValid[w] && !rawA && !rawB && !waw;
  end

  assign issueInstr = slotData[strb.issueWarp];

  // scoreboard: clears from both return ports, set on issue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbq <= '0;
    end else begin
      for (int w = 0; w < NUM_WARPS; w++) begin
        for (int r = 0; r < NUM_REGS; r++) begin
          if ((wbValid  && wbWarp  == WARP_ID_W'(w) && wbReg  == REG_W'(r)) ||
              (memValid && memWarp == WARP_ID_W'(w) && memReg == REG_W'(r)))
            sbq[w][r] <= 1'b0;
        end
      end
      if (strb.issueEn && issueInstr.writes)
        sbq[strb.issueWarp][issueInstr.dst] <= 1'b1;
    end
  end

  AST_FILL_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchWarp < WARP_ID_W'(NUM_WARPS) && slotValid[fetchWarp]) |-> !strb.fetchEn); // R3
  AST_SB_SET_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.issueEn && issueInstr.writes) |=> sbq[$past(strb.issueWarp)][$past(issueInstr.dst)]); // R6
  AST_SLOT_FREED: assert property (@(posedge clk) disable iff (!rst_n)
    strb.issueEn |=> !slotValid[$past(strb.issueWarp)]); // R6
  AST_NO_RAW_A: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.issueEn && issueInstr.useA) |-> !sbq[strb.issueWarp][issueInstr.srcA]); // R4
  AST_NO_RAW_B: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.issueEn && issueInstr.useB) |-> !sbq[strb.issueWarp][issueInstr.srcB]); // R4
  AST_NO_WAW: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.issueEn && issueInstr.writes) |-> !sbq[strb.issueWarp][issueInstr.dst]); // R5

endmodule

// File: rtl/wsched_ctrl.sv
module wsched_ctrl
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int AGE_W     = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fetchValid,
  input  warp_id_t                        fetchWarp,
  input  logic [NUM_WARPS-1:0]            slotValid,
  input  logic [NUM_WARPS-1:0]            readyVec,
  input  logic [NUM_WARPS-1:0][AGE_W-1:0] ageVec,
  output strobe_t                         strb
);

  localparam logic [WARP_ID_W:0] WARP_LIMIT = (WARP_ID_W+1)'(NUM_WARPS);
  localparam warp_id_t           LAST_WARP  = WARP_ID_W'(NUM_WARPS - 1);

  warp_id_t             rrLast;
  logic [AGE_W-1:0]     bestAge;
  logic [NUM_WARPS-1:0] tieVec;
  logic                 found;
  warp_id_t             pick;
  logic                 warpInRange;

  // oldest age among eligible warps
  always_comb begin
    bestAge = '0;
    for (int w = 0; w < NUM_WARPS; w++)
      if (readyVec[w] && ageVec[w] > bestAge) bestAge = ageVec[w];
  end

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_tie
    assign tieVec[w] = readyVec[w] && (ageVec[w] == bestAge);
  end

  // circular search starting after the last issued warp
  always_comb begin
    int idx;
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      idx = int'(rrLast) + k;
      if (idx >= NUM_WARPS) idx = idx - NUM_WARPS;
      if (!found && tieVec[idx]) begin
        found = 1'b1;
        pick  = WARP_ID_W'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rrLast <= LAST_WARP;
    else if (found)    rrLast <= pick;
  end

  assign warpInRange  = {1'b0, fetchWarp} < WARP_LIMIT;
  assign strb.fetchEn   = fetchValid && warpInRange && !slotValid[fetchWarp];
  assign strb.issueEn   = found;
  assign strb.issueWarp = pick;

  AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.issueEn |-> readyVec[strb.issueWarp]); // R8
  AST_NO_IDLE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (|readyVec) |-> strb.issueEn); // R8

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_age_chk
    AST_OLDEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.issueEn && readyVec[w]) |-> ageVec[strb.issueWarp] >= ageVec[w]); // R9
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int AGE_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetchValid,
  input  logic [WARP_ID_W-1:0] fetchWarp,
  input  logic [OPC_W-1:0]     fetchOp,
  input  logic [REG_W-1:0]     fetchDst,
  input  logic [REG_W-1:0]     fetchSrcA,
  input  logic [REG_W-1:0]     fetchSrcB,
  input  logic                 fetchUseA,
  input  logic                 fetchUseB,
  input  logic                 fetchWrites,
  input  logic                 wbValid,
  input  logic [WARP_ID_W-1:0] wbWarp,
  input  logic [REG_W-1:0]     wbReg,
  input  logic                 memValid,
  input  logic [WARP_ID_W-1:0] memWarp,
  input  logic [REG_W-1:0]     memReg,
  output logic [NUM_WARPS-1:0] slotFree,
  output logic                 issueValid,
  output logic [WARP_ID_W-1:0] issueWarp,
  output logic [OPC_W-1:0]     issueOp,
  output logic [REG_W-1:0]     issueDst,
  output logic [REG_W-1:0]     issueSrcA,
  output logic [REG_W-1:0]     issueSrcB,
  output logic                 issueUseA,
  output logic                 issueUseB,
  output logic                 issueWrites
);

  strobe_t                         strb;
  winstr_t                         fetchInstr;
  winstr_t                         issueInstr;
  logic [NUM_WARPS-1:0]            slotValid;
  logic [NUM_WARPS-1:0]            readyVec;
  logic [NUM_WARPS-1:0][AGE_W-1:0] ageVec;

  assign fetchInstr = '{op: fetchOp, dst: fetchDst, srcA: fetchSrcA, srcB: fetchSrcB,
                        useA: fetchUseA, useB: fetchUseB, writes: fetchWrites};

  wsched_ctrl #(.NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetchValid (fetchValid),
    .fetchWarp  (fetchWarp),
    .slotValid  (slotValid),
    .readyVec   (readyVec),
    .ageVec     (ageVec),
    .strb       (strb)
  );

  wsched_datapath #(.NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .fetchWarp  (fetchWarp),
    .fetchInstr (fetchInstr),
    .wbValid    (wbValid),
    .wbWarp     (wbWarp),
    .wbReg      (wbReg),
    .memValid   (memValid),
    .memWarp    (memWarp),
    .memReg     (memReg),
    .slotValid  (slotValid),
    .readyVec   (readyVec),
    .ageVec     (ageVec),
    .issueInstr (issueInstr)
  );

  assign slotFree    = ~slotValid;
  assign issueValid  = strb.issueEn;
  assign issueWarp   = strb.issueWarp;
  assign issueOp     = issueInstr.op;
  assign issueDst    = issueInstr.dst;
  assign issueSrcA   = issueInstr.srcA;
  assign issueSrcB   = issueInstr.srcB;
  assign issueUseA   = issueInstr.useA;
  assign issueUseB   = issueInstr.useB;
  assign issueWrites = issueInstr.writes;

endmodule

// File: tb/warp_issue_sched_tb.sv
`timescale 1ns/1ps
module warp_issue_sched_tb;

  localparam int NW = 24;
  localparam int NSTEP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetchValid, fetchUseA, fetchUseB, fetchWrites, wbValid, memValid;
  logic [4:0] fetchWarp, wbWarp, memWarp;
  logic [7:0] fetchOp;
  logic [3:0] fetchDst, fetchSrcA, fetchSrcB, wbReg, memReg;
  logic [NW-1:0] slotFree;
  logic issueValid, issueUseA, issueUseB, issueWrites;
  logic [4:0] issueWarp;
  logic [7:0] issueOp;
  logic [3:0] issueDst, issueSrcA, issueSrcB;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  warp_issue_sched u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetchValid(fetchValid), .fetchWarp(fetchWarp), .fetchOp(fetchOp),
    .fetchDst(fetchDst), .fetchSrcA(fetchSrcA), .fetchSrcB(fetchSrcB),
    .fetchUseA(fetchUseA), .fetchUseB(fetchUseB), .fetchWrites(fetchWrites),
    .wbValid(wbValid), .wbWarp(wbWarp), .wbReg(wbReg),
    .memValid(memValid), .memWarp(memWarp), .memReg(memReg),
    .slotFree(slotFree), .issueValid(issueValid), .issueWarp(issueWarp),
    .issueOp(issueOp), .issueDst(issueDst), .issueSrcA(issueSrcA),
    .issueSrcB(issueSrcB), .issueUseA(issueUseA), .issueUseB(issueUseB),
    .issueWrites(issueWrites)
  );

  // fetch fields, clear fields, then expected issue (valid, warp, opcode)
  typedef struct packed {
    int fv; int fw; int op; int dst; int sa; int ua; int wr;
    int wbv; int wbw; int wbr; int mv; int mw; int mr;
    int ev; int ew; int eop;
  } vec_t;

  localparam vec_t TBL [NSTEP] = '{
    '{1, 3,'hA0,1,0,0,1, 0,0,0, 0,0,0, 0,0,0},
    '{1, 3,'hA1,4,1,1,1, 0,0,0, 0,0,0, 1,3,'hA0},
    '{1, 3,'hA2,4,1,1,1, 0,0,0, 0,0,0, 0,0,0},
    '{1, 5,'hA3,2,1,1,1, 0,0,0, 0,0,0, 0,0,0},
    '{0, 0,0,0,0,0,0,    1,3,1, 0,0,0, 1,5,'hA3},
    '{0, 0,0,0,0,0,0,    0,0,0, 0,0,0, 1,3,'hA2},
    '{1, 5,'hA6,2,0,0,1, 0,0,0, 0,0,0, 0,0,0},
    '{0, 0,0,0,0,0,0,    0,0,0, 1,5,2, 0,0,0},
    '{1, 7,'hA8,0,0,0,0, 0,0,0, 0,0,0, 1,5,'hA6},
    '{0, 0,0,0,0,0,0,    1,3,4, 1,5,2, 1,7,'hA8},
    '{1,10,'hAA,6,0,0,1, 0,0,0, 0,0,0, 0,0,0},
    '{1,12,'hAB,6,0,0,1, 0,0,0, 0,0,0, 1,10,'hAA},
    '{0, 0,0,0,0,0,0,    0,0,0, 0,0,0, 1,12,'hAB},
    '{1,12,'hAD,7,6,1,1, 0,0,0, 0,0,0, 0,0,0},
    '{1,10,'hAE,7,6,1,1, 0,0,0, 0,0,0, 0,0,0},
    '{0, 0,0,0,0,0,0,    1,10,6, 1,12,6, 0,0,0},
    '{0, 0,0,0,0,0,0,    0,0,0, 0,0,0, 1,12,'hAD},
    '{0, 0,0,0,0,0,0,    0,0,0, 0,0,0, 1,10,'hAE},
    '{1,10,'hB2,0,7,1,0, 0,0,0, 0,0,0, 0,0,0},
    '{1,12,'hB3,0,7,1,0, 0,0,0, 0,0,0, 0,0,0},
    '{0,0,0,0,0,0,0, 0,0,0, 0,0,0, 0,0,0},
    '{0,0,0,0,0,0,0, 0,0,0, 0,0,0, 0,0,0},
    '{0,0,0,0,0,0,0, 0,0,0, 0,0,0, 0,0,0},
    '{0,0,0,0,0,0,0, 0,0,0, 0,0,0, 0,0,0},
    '{0,0,0,0,0,0,0, 0,0,0, 0,0,0, 0,0,0},
    '{0,0,0,0,0,0,0, 0,0,0, 0,0,0, 0,0,0},
    '{0,0,0,0,0,0,0, 0,0,0, 0,0,0, 0,0,0},
    '{0,0,0,0,0,0,0, 0,0,0, 0,0,0, 0,0,0},
    '{0, 0,0,0,0,0,0,    1,10,7, 1,12,7, 0,0,0},
    '{0, 0,0,0,0,0,0,    0,0,0, 0,0,0, 1,12,'hB3},
    '{0, 0,0,0,0,0,0,    0,0,0, 0,0,0, 1,10,'hB2},
    '{0,0,0,0,0,0,0, 0,0,0, 0,0,0, 0,0,0}
  };

  function automatic string reqOf(int i);
    case (i)
      0, 1:           return "R2";
      2, 5:           return "R3";
      3, 13, 14, 18:  return "R4";
      4:              return "R11";
      7:              return "R5";
      6, 12:          return "R6";
      8, 9, 15:       return "R7";
      11, 17:         return "R8";
      16:             return "R9";
      29, 30:         return "R10";
      default:        return "R4";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    fetchValid  = v.fv[0];
    fetchWarp   = v.fw[4:0];
    fetchOp     = v.op[7:0];
    fetchDst    = v.dst[3:0];
    fetchSrcA   = v.sa[3:0];
    fetchSrcB   = 4'd0;
    fetchUseA   = v.ua[0];
    fetchUseB   = 1'b0;
    fetchWrites = v.wr[0];
    wbValid     = v.wbv[0];
    wbWarp      = v.wbw[4:0];
    wbReg       = v.wbr[3:0];
    memValid    = v.mv[0];
    memWarp     = v.mw[4:0];
    memReg      = v.mr[3:0];
  endtask

  function automatic vec_t idleVec();
    return '{0,0,0,0,0,0,0, 0,0,0, 0,0,0, 0,0,0};
  endfunction

  function automatic vec_t fetchVec(int w, int dst, int sa, int ua, int wr);
    return '{1,w,'h55,dst,sa,ua,wr, 0,0,0, 0,0,0, 0,0,0};
  endfunction

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    drive(idleVec());
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(issueValid == 1'b0, "R1", "issueValid in reset", int'(issueValid), 0);
    check(slotFree == {NW{1'b1}}, "R1", "slotFree in reset", int'(slotFree), int'({NW{1'b1}}));
    rst_n = 1'b1;

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      check(issueValid == TBL[i].ev[0], reqOf(i), $sformatf("step %0d issueValid", i),
            int'(issueValid), TBL[i].ev);
      if (TBL[i].ev != 0) begin
        check(int'(issueWarp) == TBL[i].ew, reqOf(i), $sformatf("step %0d issueWarp", i),
              int'(issueWarp), TBL[i].ew);
        check(int'(issueOp) == TBL[i].eop, reqOf(i), $sformatf("step %0d issueOp", i),
              int'(issueOp), TBL[i].eop);
      end
      drive(TBL[i]);
    end

    // directed: fill, occupancy flag, destination carried through (R2)
    @(negedge clk);
    drive(fetchVec(20, 1, 0, 0, 1));
    @(negedge clk);
    check(slotFree[20] == 1'b0, "R2", "slotFree[20] after fill", int'(slotFree[20]), 0);
    check(issueValid && issueWarp == 5'd20 && issueDst == 4'd1, "R2", "issue of warp 20",
          int'(issueWarp), 20);
    drive(idleVec());
    @(negedge clk);
    // R6: slot emptied on issue
    check(slotFree == {NW{1'b1}} && !issueValid, "R6", "slot freed after issue",
          int'(slotFree), int'({NW{1'b1}}));
    drive(fetchVec(20, 0, 1, 1, 0));
    @(negedge clk);
    // R4: source r1 of warp 20 still pending
    check(!issueValid && slotFree[20] == 1'b0, "R4", "held on pending source",
          int'(issueValid), 0);
    drive(idleVec());
    rst_n = 1'b0;
    @(negedge clk);
    // R1: reset empties slots and scoreboard
    check(!issueValid && slotFree == {NW{1'b1}}, "R1", "state after mid-run reset",
          int'(slotFree), int'({NW{1'b1}}));
    rst_n = 1'b1;
    drive(fetchVec(20, 0, 1, 1, 0));
    @(negedge clk);
    check(issueValid && issueWarp == 5'd20, "R1", "scoreboard cleared by reset",
          int'(issueValid), 1);
    drive(fetchVec(25, 0, 0, 0, 0));
    @(negedge clk);
    // R2: warp number beyond range is dropped
    check(!issueValid && slotFree == {NW{1'b1}}, "R2", "out-of-range fetch dropped",
          int'(issueValid), 0);
    drive(idleVec());

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule